// File: doc/BRIEF.md
# Circuit Setup Network Node

This block is one router node of a narrow setup network. It runs alongside a data mesh of 4x4 nodes. A setup request names a circuit plane and a destination node. The node steers each request one hop closer to that destination, using X-first dimension-order routing. As it forwards the request, it records in a per-plane configuration table which input port now feeds which output port. The data router reads this table to switch circuit traffic without arbitration. No acknowledgement comes back, so the first data word can follow the setup at once.

When a new request needs an output that another input already holds on the same plane, the old circuit is not kept and the new request does not wait. The old mapping is removed and the new one replaces it. A one-cycle teardown pulse tells the data path which output on which plane lost its previous owner. Each input has a single holding register. When two held requests want the same output in the same cycle, the lower-numbered input wins and the other is held until the next cycle.

Top module: `cs_setup_node`

## Requirements
- R1: After a synchronous active-high reset, the node behaves as follows: no output carries a request, no teardown is flagged, every input is ready, and every table entry reads as invalid.
- R2: A destination uses bits [1:0] for X and bits [3:2] for Y. Port codes are N=0, S=1, E=2, W=3, local=4. The node picks its output in this order: E when the destination X is larger than its own X, W when it is smaller, then S when the destination Y is larger, N when it is smaller, and local when both coordinates match.
- R3: An accepted request appears on its output one clock after acceptance, with its plane and destination unchanged. Requests bound for different outputs are forwarded in the same cycle.
- R4: Forwarding a request on plane p from input i sets the table entry (p, i) valid, with the chosen output code.
- R5: On the plane being written, any other input that was mapped to the same output is invalidated. At most one input per plane maps to a given output.
- R6: Each invalidation raises, for exactly one cycle and in the same cycle as the forward, the teardown bit of that output port, together with the plane number for that port.
- R7: When several held requests target one output in a cycle, the lowest input index wins. The losers keep their request, show ready low, and are forwarded in a later cycle.
- R8: Circuits on different planes never affect each other. The same output may be owned on several planes at once without any teardown.
- R9: The table read port returns the valid bit and output code of entry (plane, input) one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Request present, one bit per input port |
| in_plane | input | 5*PLANE_W | Plane number per input |
| in_dest | input | 5*2*COORD_W | Destination per input, Y above X |
| in_ready | output | 5 | Input register can take a request this cycle |
| out_valid | output | 5 | Forwarded request, one bit per output port |
| out_plane | output | 5*PLANE_W | Plane number per output |
| out_dest | output | 5*2*COORD_W | Destination per output |
| cfg_rd_plane | input | PLANE_W | Table read plane |
| cfg_rd_port | input | 3 | Table read input port |
| cfg_rd_valid | output | 1 | Entry valid |
| cfg_rd_out | output | 3 | Entry output code |
| td_mask | output | 5 | Teardown pulse per output port |
| td_plane | output | 5*PLANE_W | Plane of each teardown |

## Verification
The embedded properties check several things on every cycle. Per plane, no two inputs may share one output. Each output has at most one winner, and input N always wins when it requests. A held loser keeps its request unchanged. A teardown only happens alongside a forward on that port. Eastward and local forwards must agree with the node's own coordinates. Only the directed scenarios can show the specific routing decisions for each destination, the exact cycle of forwarding, and that a reconfiguration removes the right entry as seen through the read port. The same holds for the order in which contending inputs are served and for the one-cycle width of the teardown pulse.

// File: rtl/cs_setup_pkg.sv
package cs_setup_pkg;
  localparam int NPORT   = 5;
  localparam int PCODE_W = 3;

  localparam logic [PCODE_W-1:0] P_N = 3'd0;
  localparam logic [PCODE_W-1:0] P_S = 3'd1;
  localparam logic [PCODE_W-1:0] P_E = 3'd2;
  localparam logic [PCODE_W-1:0] P_W = 3'd3;
  localparam logic [PCODE_W-1:0] P_L = 3'd4;

  // X first, then Y, then eject
  function automatic logic [PCODE_W-1:0] xy_route(input int unsigned dx, input int unsigned dy,
                                                   input int unsigned hx, input int unsigned hy);
    if (dx > hx)      return P_E;
    else if (dx < hx) return P_W;
    else if (dy > hy) return P_S;
    else if (dy < hy) return P_N;
    else              return P_L;
  endfunction
endpackage

// File: rtl/cs_setup_inport.sv
module cs_setup_inport
  import cs_setup_pkg::*;
#(
  parameter int PLANE_W = 2,
  parameter int COORD_W = 2,
  parameter int NODE_X  = 1,
  parameter int NODE_Y  = 2,
  localparam int DEST_W = 2*COORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_v,
  input  logic [PLANE_W-1:0] req_plane,
  input  logic [DEST_W-1:0]  req_dest,
  input  logic               grant,
  output logic               ready,
  output logic               hold_v,
  output logic [PLANE_W-1:0] hold_plane,
  output logic [DEST_W-1:0]  hold_dest,
  output logic [PCODE_W-1:0] route
);
  assign ready = ~hold_v | grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v     <= 1'b0;
      hold_plane <= '0;
      hold_dest  <= '0;
    end else if (ready) begin
      hold_v     <= req_v;
      hold_plane <= req_plane;
      hold_dest  <= req_dest;
    end
  end

  always_comb begin
    route = xy_route(int'(hold_dest[COORD_W-1:0]), int'(hold_dest[DEST_W-1:COORD_W]),
                     NODE_X, NODE_Y);
  end

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !grant) |=> (hold_v && $stable(hold_plane) && $stable(hold_dest))); // R7
endmodule

// File: rtl/cs_setup_arb.sv
module cs_setup_arb
  import cs_setup_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         req_v,
  input  logic [NPORT*PCODE_W-1:0] req_route,
  output logic [NPORT-1:0]         grant
);
  always_comb begin
    grant = '0;
    for (int o = 0; o < NPORT; o++) begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        if (!taken && req_v[i] && req_route[i*PCODE_W +: PCODE_W] == PCODE_W'(o)) begin
          grant[i] = 1'b1;
          taken    = 1'b1;
        end
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    logic [NPORT-1:0] won;
    for (genvar i = 0; i < NPORT; i++) begin : g_in
      assign won[i] = grant[i] && (req_route[i*PCODE_W +: PCODE_W] == PCODE_W'(o));
    end
    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
      $countones(won) <= 1); // R7
  end

  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    req_v[0] |-> grant[0]); // R7
endmodule

// File: rtl/cs_setup_cfgtab.sv
module cs_setup_cfgtab
  import cs_setup_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int PLANE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         wr_v,
  input  logic [NPORT*PLANE_W-1:0] wr_plane,
  input  logic [NPORT*PCODE_W-1:0] wr_out,
  input  logic [PLANE_W-1:0]       rd_plane,
  input  logic [PCODE_W-1:0]       rd_port,
  output logic                     rd_valid,
  output logic [PCODE_W-1:0]       rd_out,
  output logic [NPORT-1:0]         td_mask,
  output logic [NPORT*PLANE_W-1:0] td_plane
);
  logic               tab_v [PLANES][NPORT];
  logic [PCODE_W-1:0] tab_o [PLANES][NPORT];
  logic               nxt_v [PLANES][NPORT];
  logic [PCODE_W-1:0] nxt_o [PLANES][NPORT];
  logic [NPORT-1:0]         td_n;
  logic [NPORT*PLANE_W-1:0] tdp_n;

  always_comb begin
    nxt_v = tab_v;
    nxt_o = tab_o;
    td_n  = '0;
    tdp_n = '0;
    // teardown of rival owners of the claimed output
    for (int i = 0; i < NPORT; i++) begin
      if (wr_v[i]) begin
        for (int j = 0; j < NPORT; j++) begin
          if (j != i && tab_v[wr_plane[i*PLANE_W +: PLANE_W]][j] &&
              tab_o[wr_plane[i*PLANE_W +: PLANE_W]][j] == wr_out[i*PCODE_W +: PCODE_W]) begin
            nxt_v[wr_plane[i*PLANE_W +: PLANE_W]][j] = 1'b0;
            td_n[wr_out[i*PCODE_W +: PCODE_W]] = 1'b1;
            tdp_n[wr_out[i*PCODE_W +: PCODE_W]*PLANE_W +: PLANE_W] = wr_plane[i*PLANE_W +: PLANE_W];
          end
        end
      end
    end
    // new mappings take precedence
    for (int i = 0; i < NPORT; i++) begin
      if (wr_v[i]) begin
        nxt_v[wr_plane[i*PLANE_W +: PLANE_W]][i] = 1'b1;
        nxt_o[wr_plane[i*PLANE_W +: PLANE_W]][i] = wr_out[i*PCODE_W +: PCODE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < PLANES; p++) begin
        for (int i = 0; i < NPORT; i++) begin
          tab_v[p][i] <= 1'b0;
          tab_o[p][i] <= '0;
        end
      end
      td_mask  <= '0;
      td_plane <= '0;
      rd_valid <= 1'b0;
      rd_out   <= '0;
    end else begin
      tab_v    <= nxt_v;
      tab_o    <= nxt_o;
      td_mask  <= td_n;
      td_plane <= tdp_n;
      if (rd_port < PCODE_W'(NPORT)) begin
        rd_valid <= tab_v[rd_plane][rd_port];
        rd_out   <= tab_o[rd_plane][rd_port];
      end else begin
        rd_valid <= 1'b0;
        rd_out   <= '0;
      end
    end
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_pl
    for (genvar o = 0; o < NPORT; o++) begin : g_out
      logic [NPORT-1:0] own;
      for (genvar i = 0; i < NPORT; i++) begin : g_in
        assign own[i] = tab_v[p][i] && (tab_o[p][i] == PCODE_W'(o));
      end
      AST_OUT_UNIQUE: assert property (@(posedge clk) disable iff (rst)
        $countones(own) <= 1); // R5
    end
  end

  AST_RD_CODE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_out < PCODE_W'(NPORT))); // R9
endmodule

// File: rtl/cs_setup_node.sv
module cs_setup_node
  import cs_setup_pkg::*;
#(
  parameter int PLANES  = 4,
  parameter int COORD_W = 2,
  parameter int NODE_X  = 1,
  parameter int NODE_Y  = 2,
  localparam int PLANE_W = $clog2(PLANES),
  localparam int DEST_W  = 2*COORD_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORT-1:0]         in_valid,
  input  logic [NPORT*PLANE_W-1:0] in_plane,
  input  logic [NPORT*DEST_W-1:0]  in_dest,
  output logic [NPORT-1:0]         in_ready,
  output logic [NPORT-1:0]         out_valid,
  output logic [NPORT*PLANE_W-1:0] out_plane,
  output logic [NPORT*DEST_W-1:0]  out_dest,
  input  logic [PLANE_W-1:0]       cfg_rd_plane,
  input  logic [PCODE_W-1:0]       cfg_rd_port,
  output logic                     cfg_rd_valid,
  output logic [PCODE_W-1:0]       cfg_rd_out,
  output logic [NPORT-1:0]         td_mask,
  output logic [NPORT*PLANE_W-1:0] td_plane
);
  logic [NPORT-1:0]         hold_v;
  logic [NPORT*PLANE_W-1:0] hold_plane;
  logic [NPORT*DEST_W-1:0]  hold_dest;
  logic [NPORT*PCODE_W-1:0] hold_route;
  logic [NPORT-1:0]         grant;

  for (genvar i = 0; i < NPORT; i++) begin : g_inp
    cs_setup_inport #(
      .PLANE_W(PLANE_W), .COORD_W(COORD_W), .NODE_X(NODE_X), .NODE_Y(NODE_Y)
    ) u_inp (
      .clk       (clk),
      .rst       (rst),
      .req_v     (in_valid[i]),
      .req_plane (in_plane[i*PLANE_W +: PLANE_W]),
      .req_dest  (in_dest[i*DEST_W +: DEST_W]),
      .grant     (grant[i]),
      .ready     (in_ready[i]),
      .hold_v    (hold_v[i]),
      .hold_plane(hold_plane[i*PLANE_W +: PLANE_W]),
      .hold_dest (hold_dest[i*DEST_W +: DEST_W]),
      .route     (hold_route[i*PCODE_W +: PCODE_W])
    );
  end

  cs_setup_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .req_v    (hold_v),
    .req_route(hold_route),
    .grant    (grant)
  );

  cs_setup_cfgtab #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_tab (
    .clk     (clk),
    .rst     (rst),
    .wr_v    (grant),
    .wr_plane(hold_plane),
    .wr_out  (hold_route),
    .rd_plane(cfg_rd_plane),
    .rd_port (cfg_rd_port),
    .rd_valid(cfg_rd_valid),
    .rd_out  (cfg_rd_out),
    .td_mask (td_mask),
    .td_plane(td_plane)
  );

  logic [NPORT-1:0]         nv;
  logic [NPORT*PLANE_W-1:0] np;
  logic [NPORT*DEST_W-1:0]  nd;

  always_comb begin
    nv = '0;
    np = '0;
    nd = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (grant[i] && hold_route[i*PCODE_W +: PCODE_W] == PCODE_W'(o)) begin
          nv[o] = 1'b1;
          np[o*PLANE_W +: PLANE_W] = hold_plane[i*PLANE_W +: PLANE_W];
          nd[o*DEST_W +: DEST_W]   = hold_dest[i*DEST_W +: DEST_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      out_plane <= '0;
      out_dest  <= '0;
    end else begin
      out_valid <= nv;
      out_plane <= np;
      out_dest  <= nd;
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_tdchk
    AST_TD_WITH_FWD: assert property (@(posedge clk) disable iff (rst)
      td_mask[o] |-> out_valid[o]); // R6
  end

  AST_EAST_ROUTE: assert property (@(posedge clk) disable iff (rst)
    out_valid[P_E] |-> (int'(out_dest[P_E*DEST_W +: COORD_W]) > NODE_X)); // R2

  AST_LOCAL_ROUTE: assert property (@(posedge clk) disable iff (rst)
    out_valid[P_L] |-> (int'(out_dest[P_L*DEST_W +: COORD_W]) == NODE_X &&
                        int'(out_dest[P_L*DEST_W+COORD_W +: COORD_W]) == NODE_Y)); // R2
endmodule

// File: tb/test_cs_setup_node.sv
`timescale 1ns/1ps
module test_cs_setup_node;
  localparam int NP = 5;
  localparam int PW = 2;
  localparam int DW = 4;
  localparam int PN = 0, PS = 1, PE = 2, PWs = 3, PL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    in_valid = '0;
  logic [NP*PW-1:0] in_plane = '0;
  logic [NP*DW-1:0] in_dest = '0;
  logic [NP-1:0]    in_ready;
  logic [NP-1:0]    out_valid;
  logic [NP*PW-1:0] out_plane;
  logic [NP*DW-1:0] out_dest;
  logic [PW-1:0]    cfg_rd_plane = '0;
  logic [2:0]       cfg_rd_port = '0;
  logic             cfg_rd_valid;
  logic [2:0]       cfg_rd_out;
  logic [NP-1:0]    td_mask;
  logic [NP*PW-1:0] td_plane;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cs_setup_node i_cs_setup_node (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_plane(in_plane), .in_dest(in_dest),
    .in_ready(in_ready), .out_valid(out_valid), .out_plane(out_plane), .out_dest(out_dest),
    .cfg_rd_plane(cfg_rd_plane), .cfg_rd_port(cfg_rd_port), .cfg_rd_valid(cfg_rd_valid),
    .cfg_rd_out(cfg_rd_out), .td_mask(td_mask), .td_plane(td_plane)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input int p, input int pl, input int dx, input int dy);
    in_valid[p] = 1'b1;
    in_plane[p*PW +: PW] = PW'(pl);
    in_dest[p*DW +: DW] = {2'(dy), 2'(dx)};
  endtask

  // called at a negedge; returns at the negedge after one clock
  task automatic rd(input int pl, input int pt, output int v, output int o);
    cfg_rd_plane = PW'(pl);
    cfg_rd_port = 3'(pt);
    @(negedge clk);
    v = int'(cfg_rd_valid);
    o = int'(cfg_rd_out);
  endtask

  task automatic send1(input string req, input int p, input int pl, input int dx, input int dy,
                       input int exp_o);
    @(negedge clk); drive(p, pl, dx, dy);
    @(negedge clk); in_valid = '0;
    @(negedge clk);
    check({req, " out_valid"}, int'(out_valid), 1 << exp_o);
    check({req, " plane"}, int'(out_plane[exp_o*PW +: PW]), pl);
    check({req, " dest"}, int'(out_dest[exp_o*DW +: DW]), dy*4 + dx);
  endtask

  task automatic t_reset();
    int v, o;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 td_mask", int'(td_mask), 0);
    check("R1 in_ready", int'(in_ready), 31);
    rd(0, 0, v, o); check("R1 entry 0/0", v, 0);
    rd(3, 4, v, o); check("R1 entry 3/4", v, 0);
  endtask

  task automatic t_route();
    int v, o;
    send1("R2 east", PL, 0, 3, 0, PE);
    send1("R2 west", PL, 0, 0, 3, PWs);
    send1("R2 north", PL, 0, 1, 0, PN);
    send1("R2 south", PL, 0, 1, 3, PS);
    send1("R3 local", PL, 0, 1, 2, PL);
    check("R6 no teardown on self overwrite", int'(td_mask), 0);
    rd(0, PL, v, o);
    check("R4 entry valid", v, 1);
    check("R9 entry code", o, PL);
  endtask

  task automatic t_reconf();
    int v, o;
    send1("R4 first owner", PN, 1, 3, 2, PE);
    check("R6 none yet", int'(td_mask), 0);
    send1("R5 steal", PWs, 1, 3, 0, PE);
    check("R6 td mask", int'(td_mask), 1 << PE);
    check("R6 td plane", int'(td_plane[PE*PW +: PW]), 1);
    @(negedge clk);
    check("R6 one cycle", int'(td_mask), 0);
    rd(1, PN, v, o); check("R5 old cleared", v, 0);
    rd(1, PWs, v, o);
    check("R4 new valid", v, 1);
    check("R4 new code", o, PE);
  endtask

  task automatic t_planes();
    int v, o;
    send1("R8 plane2", PS, 2, 3, 1, PE);
    send1("R8 plane3", PWs, 3, 2, 2, PE);
    check("R8 no teardown", int'(td_mask), 0);
    rd(2, PS, v, o); check("R8 plane2 kept", v, 1);
    rd(3, PWs, v, o); check("R8 plane3 code", o, PE);
  endtask

  task automatic t_conflict();
    int v, o;
    @(negedge clk); drive(PN, 0, 3, 0); drive(PS, 0, 2, 3);
    @(negedge clk); in_valid = '0;
    check("R7 loser not ready", int'(in_ready), 5'b11101);
    @(negedge clk);
    check("R7 winner out", int'(out_valid), 1 << PE);
    check("R7 winner dest", int'(out_dest[PE*DW +: DW]), 4'b0011);
    check("R7 no td first", int'(td_mask), 0);
    @(negedge clk);
    check("R7 loser out", int'(out_valid), 1 << PE);
    check("R7 loser dest", int'(out_dest[PE*DW +: DW]), 4'b1110);
    check("R5 td on loser forward", int'(td_mask), 1 << PE);
    check("R6 td plane 0", int'(td_plane[PE*PW +: PW]), 0);
    rd(0, PN, v, o); check("R5 N cleared", v, 0);
    rd(0, PS, v, o); check("R4 S owns E", o, PE);
  endtask

  task automatic t_parallel();
    @(negedge clk); drive(PE, 3, 0, 2); drive(PWs, 3, 3, 2);
    @(negedge clk); in_valid = '0;
    @(negedge clk);
    check("R3 both outputs", int'(out_valid), (1 << PWs) | (1 << PE));
    check("R3 west dest", int'(out_dest[PWs*DW +: DW]), 4'b1000);
    check("R3 east dest", int'(out_dest[PE*DW +: DW]), 4'b1011);
    check("R8 no td parallel", int'(td_mask), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_route();
    t_reconf();
    t_planes();
    t_conflict();
    t_parallel();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule